// File: doc/BRIEF.md
# Snapshot-Guarded Receive Event Register

This block keeps an 8-bit register of receive-side line events next to a snapshot register. Line-state detection logic raises per-bit set pulses, and a host reaches both registers through a plain address/read/write bus. The guard stops a host from clearing an event that hardware raised after the host last looked at the register.

Every host read of the event register copies its live value into the snapshot register on that clock edge. On a later host write to the event register, each bit takes the written value only if its live value still equals its snapshot bit. A bit that moved since the read keeps its live value, and the write raises a sticky write-inhibited flag. That flag is visible in an interrupt-condition register and on its own output pin. Software can also load the snapshot directly at its own address.

Event bits, from bit 0 up, are: signal lost, quiet line, halt line, master line, noise line, noise threshold crossed, line state changed, and unknown line state or invalid physical layer.

Top module: `rxcond_guard`

## Requirements
- R1: After reset the event register, the snapshot register (address 0x1C) and the write-inhibited flag all read 0.
- R2: A 1 on bit i of `line_set` sets event bit i on the next clock edge, and the bit stays set while no host write touches it.
- R3: A host read at the event address (0x0E) returns the live event value and copies it into the snapshot register. A read of 0x1C then returns that value.
- R4: On a host write to 0x0E, every event bit whose live value equals its snapshot bit takes the written data bit.
- R5: On a host write to 0x0E, every event bit whose live value differs from its snapshot bit keeps its live value.
- R6: A write to 0x0E with at least one mismatching bit sets the write-inhibited flag to 1. The flag is bit 0 of the interrupt-condition register at 0x04 and also drives `cond_inhibit`. A write with no mismatching bit leaves the flag unchanged.
- R7: When a `line_set` bit is high in the same cycle as a host write to 0x0E, that event bit ends at 1.
- R8: The write-inhibited flag stays at 1 until the host writes 0x04 with bit 0 set. A write of 0x04 with bit 0 clear leaves it at 1.
- R9: A host write to 0x1C loads the snapshot register directly with the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_set | input | 8 | Per-bit event set pulses from line-state logic |
| bus_addr | input | 5 | Host register address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the addressed register (combinational) |
| cond_inhibit | output | 1 | Sticky write-inhibited flag |

## Verification
The assertions assume the host never raises read and write strobes in the same cycle, and one assertion checks that rule. The bench drives every bus access as a single strobe cycle between falling edges, so it always stays within that rule. Set pulses are held off during sweep trials, except in the cases that deliberately collide a pulse with a write. This lets each written result be predicted from the live value, the snapshot and the data alone. The sweeps build every live value by clearing through a matched write and then pulsing, and they force the snapshot through its own address.

// File: rtl/rxcond_guard.sv
module rxcond_guard #(
  parameter int         W        = 8,
  parameter int         AW       = 5,
  parameter logic [4:0] EVT_ADDR = 5'h0E,
  parameter logic [4:0] INT_ADDR = 5'h04,
  parameter logic [4:0] CMP_ADDR = 5'h1C,
  parameter int         INH_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  line_set,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          cond_inhibit
);

  logic [W-1:0] cond_q, snap_q, cond_d, stale, int_view;
  logic         inh_q;

  wire sel_evt = (bus_addr == AW'(EVT_ADDR));
  wire sel_int = (bus_addr == AW'(INT_ADDR));
  wire sel_cmp = (bus_addr == AW'(CMP_ADDR));

  wire wr_evt = bus_wr & sel_evt;
  wire wr_int = bus_wr & sel_int;
  wire wr_cmp = bus_wr & sel_cmp;
  wire rd_evt = bus_rd & sel_evt & ~bus_wr;

  assign stale  = cond_q ^ snap_q;
  assign cond_d = (wr_evt ? ((cond_q & stale) | (bus_wdata & ~stale)) : cond_q) | line_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= '0;
      snap_q <= '0;
      inh_q  <= 1'b0;
    end else begin
      cond_q <= cond_d;
      if (wr_cmp)      snap_q <= bus_wdata;
      else if (rd_evt) snap_q <= cond_q;
      if (wr_evt && (|stale))              inh_q <= 1'b1;
      else if (wr_int && bus_wdata[INH_BIT]) inh_q <= 1'b0;
    end
  end

  always_comb begin
    int_view          = '0;
    int_view[INH_BIT] = inh_q;
    unique case (1'b1)
      sel_evt: bus_rdata = cond_q;
      sel_int: bus_rdata = int_view;
      sel_cmp: bus_rdata = snap_q;
      default: bus_rdata = '0;
    endcase
  end

  assign cond_inhibit = inh_q;

endmodule

// File: rtl/rxcond_guard_chk.sv
module rxcond_guard_chk #(
  parameter int         W        = 8,
  parameter int         AW       = 5,
  parameter logic [4:0] EVT_ADDR = 5'h0E,
  parameter logic [4:0] INT_ADDR = 5'h04,
  parameter int         INH_BIT  = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  line_set,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [W-1:0]  bus_wdata,
  input logic          cond_inhibit,
  input logic [W-1:0]  cond_q,
  input logic [W-1:0]  snap_q
);

  wire hit_evt = (bus_addr == AW'(EVT_ADDR));
  wire hit_int = (bus_addr == AW'(INT_ADDR));

  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R2
  set_pulse_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_set) |=> ((cond_q & $past(line_set)) == $past(line_set)));

  // R3
  read_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && hit_evt) |=> (snap_q == $past(cond_q)));

  // R5
  stale_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_evt) |=>
      (((cond_q ^ $past(cond_q)) & ($past(cond_q) ^ $past(snap_q)) & ~$past(line_set)) == '0));

  // R6
  inhibit_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_evt && (cond_q != snap_q)) |=> cond_inhibit);

  // R8
  inhibit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_inhibit && !(bus_wr && hit_int && bus_wdata[INH_BIT])) |=> cond_inhibit);

endmodule

bind rxcond_guard rxcond_guard_chk #(
  .W(W), .AW(AW), .EVT_ADDR(EVT_ADDR), .INT_ADDR(INT_ADDR), .INH_BIT(INH_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_set(line_set), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .cond_inhibit(cond_inhibit), .cond_q(cond_q), .snap_q(snap_q)
);

// File: tb/sim_rxcond_guard.sv
module sim_rxcond_guard;
  localparam logic [4:0] A_EVT = 5'h0E, A_INT = 5'h04, A_CMP = 5'h1C;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] line_set = '0, bus_wdata = '0;
  logic [4:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       cond_inhibit;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rxcond_guard u0 (.clk(clk), .rst_n(rst_n), .line_set(line_set), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cond_inhibit(cond_inhibit));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [7:0] s = 8'h00);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1; line_set = s;
    @(negedge clk); bus_wr = 1'b0; line_set = '0;
  endtask

  task automatic pulse(input logic [7:0] s);
    @(negedge clk); line_set = s;
    @(negedge clk); line_set = '0;
  endtask

  task automatic make_live(input logic [7:0] a);
    logic [7:0] t;
    rd(A_EVT, t);
    wr(A_EVT, 8'h00);
    if (a != 0) pulse(a);
    wr(A_INT, 8'h01);
  endtask

  task automatic trial(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d);
    logic [7:0] m, got;
    make_live(a);
    wr(A_CMP, s);
    wr(A_EVT, d);
    m = a ^ s;
    rd(A_EVT, got);
    check("R4/R5", got, (a & m) | (d & ~m));
    check("R6", {7'b0, cond_inhibit}, {7'b0, (m != 0)});
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd(A_EVT, v); check("R1 evt", v, 8'h00);
    rd(A_CMP, v); check("R1 cmp", v, 8'h00);
    rd(A_INT, v); check("R1 inh", v, 8'h00);

    pulse(8'h21);
    rd(A_EVT, v); check("R2", v, 8'h21);
    pulse(8'h80);
    rd(A_EVT, v); check("R2 sticky", v, 8'hA1);
    rd(A_CMP, v); check("R3", v, 8'hA1);

    wr(A_CMP, 8'h5A);
    rd(A_CMP, v); check("R9", v, 8'h5A);

    wr(A_EVT, 8'h00);
    rd(A_INT, v); check("R6 flag", v, 8'h01);
    wr(A_INT, 8'h00);
    check("R8 write0", {7'b0, cond_inhibit}, 8'h01);
    wr(A_INT, 8'h01);
    check("R8 clear", {7'b0, cond_inhibit}, 8'h00);

    make_live(8'h0F);
    rd(A_EVT, v);
    wr(A_EVT, 8'h00, 8'h03);
    rd(A_EVT, v); check("R7", v, 8'h03);
    check("R7 inh", {7'b0, cond_inhibit}, 8'h00);

    for (int i = 0; i < 256; i++)
      trial(8'(i), 8'(i * 37 + 11), 8'(i * 91 + 5));
    for (int i = 0; i < 256; i++)
      trial(8'(i * 13 + 7), 8'(i * 13 + 7) ^ 8'(1 << (i % 8)), 8'(~i));
    for (int i = 0; i < 64; i++)
      trial(8'(i * 5), 8'(i * 5), 8'(i * 29 + 3));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule